// File: doc/BRIEF.md
# Three-Wire Serial Reference Control Port

This block is a write-only serial port that takes one 12-bit command per frame. A frame is enclosed by an active-low enable. Each command does one of two things. It can load one of two 8-bit reference codes, or it can move a grounded-output flag. The two codes are registered outputs for the downstream reference converters. The flag tells the video outputs and the first reference output to pull to ground. A test-force input overrides the flag and keeps the effective mode at normal.

The serial clock, data and enable arrive asynchronously. Each one passes through a two-flop synchroniser into the system clock domain, and its edges are detected there. For this to work, the system clock must run at least four times faster than the serial clock. The received word takes effect only when the enable rises, and only if exactly twelve serial clock edges were seen during the frame. Any other frame is dropped without effect.

Top module: `ser_ctl_port`

## Requirements
- R1: After reset both reference codes read 0x00, and the grounded flag and the effective ground output both read 1.
- R2: Command field (frame bits 11:10) value 00 loads frame bits 7:0 into reference code B. Code A and the grounded flag stay unchanged.
- R3: Command value 01 loads frame bits 7:0 into reference code A and clears the grounded flag. Code B stays unchanged.
- R4: Command value 10 clears the grounded flag and leaves both codes unchanged.
- R5: Command value 11 sets the grounded flag and leaves both codes unchanged.
- R6: Bits are taken on serial clock rising edges while the enable is low, most significant (bit 11) first. Bit 7 is the code MSB, and frame bits 9:8 have no effect.
- R7: Outputs change only after the enable rises. A complete frame held open with the enable low leaves every output unchanged.
- R8: A frame whose enable rises after fewer or more than 12 serial clock rising edges changes no output.
- R9: Serial clock and data activity while the enable is high has no effect, either on the outputs or on the next frame.
- R10: The effective ground output equals the grounded flag while test force is low, and reads 0 while test force is high. The flag itself is not changed by test force.
- R11: A serial clock rising edge that falls in the same system clock cycle as the enable rising edge is not counted as a frame bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock, asynchronous |
| sdata_i | input | 1 | Serial data, asynchronous |
| sen_ni | input | 1 | Active-low frame enable, asynchronous |
| test_force_i | input | 1 | Forces the effective mode to normal |
| ref_a_o | output | 8 | Reference code A |
| ref_b_o | output | 8 | Reference code B |
| gnd_flag_o | output | 1 | Stored grounded-mode flag |
| gnd_eff_o | output | 1 | Effective ground request to the outputs |

## Verification
Two events can be detected in the same system clock cycle: the closing enable edge and a serial clock rising edge. The bench sends twelve ordinary bits and then changes the serial clock and the enable in the same time step, so both synchronisers pass the new values through together. The result is judged at the outputs. The frame must commit with the twelve-bit payload, which shows that the coincident edge was neither counted as a thirteenth bit nor allowed to cause the frame to be discarded.

// File: rtl/ser_ctl_pkg.sv
package ser_ctl_pkg;
  localparam int FRAME_BITS = 12;
  localparam int CODE_W     = 8;

  typedef enum logic [1:0] {
    CMD_LOAD_B  = 2'b00,
    CMD_LOAD_A  = 2'b01,
    CMD_RELEASE = 2'b10,
    CMD_GROUND  = 2'b11
  } cmd_e;
endpackage

// File: rtl/ser_ctl_sync.sv
module ser_ctl_sync #(
  parameter int          WIDTH   = 3,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic meta_q, sync_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q <= RST_VAL[i];
        sync_q <= RST_VAL[i];
      end else begin
        meta_q <= d_i[i];
        sync_q <= meta_q;
      end
    end
    assign q_o[i] = sync_q;
  end
endmodule

// File: rtl/ser_ctl_rx.sv
module ser_ctl_rx #(
  parameter int FRAME_BITS = 12
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  sclk_s_i,
  input  logic                  sdata_s_i,
  input  logic                  sen_s_i,
  output logic                  commit_o,
  output logic [FRAME_BITS-1:0] frame_o
);
  localparam int CNT_MAX = FRAME_BITS + 1;   // saturating "too many" value
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic             sclk_d_q, sen_d_q;
  logic             scl_rise, sen_fall, sen_rise;
  logic [CNT_W-1:0] cnt_q;
  logic [FRAME_BITS-1:0] sr_q;
  logic             commit_q;

  assign scl_rise = sclk_s_i & ~sclk_d_q;
  assign sen_fall = ~sen_s_i & sen_d_q;
  assign sen_rise = sen_s_i & ~sen_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_d_q <= 1'b0;
      sen_d_q  <= 1'b1;
    end else begin
      sclk_d_q <= sclk_s_i;
      sen_d_q  <= sen_s_i;
    end
  end

  // edges count only while the synchronised enable is low
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sr_q  <= '0;
    end else if (sen_fall) begin
      cnt_q <= scl_rise ? CNT_W'(1) : '0;
      if (scl_rise) sr_q <= {sr_q[FRAME_BITS-2:0], sdata_s_i};
    end else if (!sen_s_i && scl_rise) begin
      if (cnt_q != CNT_W'(CNT_MAX)) cnt_q <= cnt_q + 1'b1;
      sr_q <= {sr_q[FRAME_BITS-2:0], sdata_s_i};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) commit_q <= 1'b0;
    else         commit_q <= sen_rise && (cnt_q == CNT_W'(FRAME_BITS));
  end

  assign commit_o = commit_q;
  assign frame_o  = sr_q;

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(CNT_MAX)); // R8
  AST_COMMIT_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> (cnt_q == CNT_W'(FRAME_BITS))); // R8
  AST_IDLE_NO_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sen_s_i && sen_d_q) |=> $stable(cnt_q)); // R9
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_rise && !sen_s_i && !sen_fall && cnt_q < CNT_W'(CNT_MAX))
      |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1))); // R6
endmodule

// File: rtl/ser_ctl_regs.sv
module ser_ctl_regs
  import ser_ctl_pkg::*;
#(
  parameter int CODE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              commit_i,
  input  cmd_e              cmd_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [CODE_W-1:0] ref_a_o,
  output logic [CODE_W-1:0] ref_b_o,
  output logic              gnd_flag_o
);
  logic [CODE_W-1:0] ref_a_q, ref_b_q;
  logic              gnd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_a_q <= '0;
      ref_b_q <= '0;
      gnd_q   <= 1'b1;
    end else if (commit_i) begin
      unique case (cmd_i)
        CMD_LOAD_B:  ref_b_q <= code_i;
        CMD_LOAD_A: begin
          ref_a_q <= code_i;
          gnd_q   <= 1'b0;
        end
        CMD_RELEASE: gnd_q <= 1'b0;
        CMD_GROUND:  gnd_q <= 1'b1;
        default: ;
      endcase
    end
  end

  assign ref_a_o    = ref_a_q;
  assign ref_b_o    = ref_b_q;
  assign gnd_flag_o = gnd_q;

  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> ($stable(ref_a_q) && $stable(ref_b_q) && $stable(gnd_q))); // R7
  AST_GROUND_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && cmd_i == CMD_GROUND) |=> (gnd_q && $stable(ref_a_q) && $stable(ref_b_q))); // R5
  AST_RELEASE_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && cmd_i == CMD_RELEASE) |=> (!gnd_q && $stable(ref_a_q) && $stable(ref_b_q))); // R4
  AST_LOAD_B_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && cmd_i == CMD_LOAD_B) |=> ($stable(ref_a_q) && $stable(gnd_q))); // R2
  AST_LOAD_A_REL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && cmd_i == CMD_LOAD_A) |=> (!gnd_q && $stable(ref_b_q))); // R3
endmodule

// File: rtl/ser_ctl_port.sv
module ser_ctl_port
  import ser_ctl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              sdata_i,
  input  logic              sen_ni,
  input  logic              test_force_i,
  output logic [CODE_W-1:0] ref_a_o,
  output logic [CODE_W-1:0] ref_b_o,
  output logic              gnd_flag_o,
  output logic              gnd_eff_o
);
  localparam int CMD_HI = FRAME_BITS - 1;

  logic [2:0]            sync_q;
  logic                  commit;
  logic [FRAME_BITS-1:0] frame;
  logic [1:0]            frame_unused;
  logic                  gnd_flag;

  // {enable, data, clock}; enable idles high
  ser_ctl_sync #(.WIDTH(3), .RST_VAL(3'b100)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({sen_ni, sdata_i, sclk_i}),
    .q_o    (sync_q)
  );

  ser_ctl_rx #(.FRAME_BITS(FRAME_BITS)) i_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sclk_s_i  (sync_q[0]),
    .sdata_s_i (sync_q[1]),
    .sen_s_i   (sync_q[2]),
    .commit_o  (commit),
    .frame_o   (frame)
  );

  assign frame_unused = frame[CMD_HI-2 -: 2];

  ser_ctl_regs #(.CODE_W(CODE_W)) i_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .commit_i   (commit),
    .cmd_i      (cmd_e'(frame[CMD_HI -: 2])),
    .code_i     (frame[CODE_W-1:0]),
    .ref_a_o    (ref_a_o),
    .ref_b_o    (ref_b_o),
    .gnd_flag_o (gnd_flag)
  );

  assign gnd_flag_o = gnd_flag;
  assign gnd_eff_o  = gnd_flag & ~test_force_i;
endmodule

// File: tb/test_ser_ctl_port.sv
module test_ser_ctl_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sclk = 1'b0, sdata = 1'b0, sen_n = 1'b1, tforce = 1'b0;
  logic [7:0] ref_a, ref_b;
  logic       gnd_flag, gnd_eff;
  int         errors = 0, checks = 0;
  bit         done = 1'b0;

  localparam int HALF = 6;  // system clocks per serial clock phase

  always #4 clk = ~clk;

  ser_ctl_port i_ser_ctl_port (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .sdata_i(sdata), .sen_ni(sen_n),
    .test_force_i(tforce), .ref_a_o(ref_a), .ref_b_o(ref_b),
    .gnd_flag_o(gnd_flag), .gnd_eff_o(gnd_eff)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic open_and_shift(input logic [15:0] w, input int n);
    sen_n = 1'b0;
    wait_clk(HALF);
    for (int i = n - 1; i >= 0; i--) begin
      sdata = w[i];
      wait_clk(HALF);
      sclk = 1'b1;
      wait_clk(HALF);
      sclk = 1'b0;
    end
    wait_clk(HALF);
  endtask

  task automatic close_frame();
    sen_n = 1'b1;
    wait_clk(10);
  endtask

  task automatic send(input logic [15:0] w, input int n);
    open_and_shift(w, n);
    close_frame();
  endtask

  task automatic expect_all(input string req, input int a, input int b, input int g);
    check({req, " ref_a"}, ref_a, a);
    check({req, " ref_b"}, ref_b, b);
    check({req, " gnd_flag"}, gnd_flag, g);
  endtask

  task automatic t_reset();
    expect_all("R1", 8'h00, 8'h00, 1);
    check("R1 gnd_eff", gnd_eff, 1);
  endtask

  task automatic t_load_b();  // bits 9:8 set, must be ignored
    send(16'h03A5, 12);
    expect_all("R2 R6", 8'h00, 8'hA5, 1);
  endtask

  task automatic t_load_a();
    send(16'h043C, 12);
    expect_all("R3", 8'h3C, 8'hA5, 0);
  endtask

  task automatic t_ground();
    send(16'h0CFF, 12);
    expect_all("R5", 8'h3C, 8'hA5, 1);
  endtask

  task automatic t_release();
    send(16'h0800, 12);
    expect_all("R4", 8'h3C, 8'hA5, 0);
  endtask

  task automatic t_hold_open();
    open_and_shift(16'h005A, 12);
    wait_clk(20);
    expect_all("R7 open", 8'h3C, 8'hA5, 0);
    close_frame();
    expect_all("R7 closed", 8'h3C, 8'h5A, 0);
  endtask

  task automatic t_idle_scl();
    for (int i = 0; i < 5; i++) begin
      sdata = i[0];
      wait_clk(HALF);
      sclk = 1'b1;
      wait_clk(HALF);
      sclk = 1'b0;
    end
    wait_clk(10);
    expect_all("R9 idle", 8'h3C, 8'h5A, 0);
    send(16'h0412, 12);  // bit reversal would give 0x48
    expect_all("R9 R6 next", 8'h12, 8'h5A, 0);
  endtask

  task automatic t_bad_len();
    send(16'h04FF, 11);
    expect_all("R8 short", 8'h12, 8'h5A, 0);
    send(16'h0CFF, 13);
    expect_all("R8 long", 8'h12, 8'h5A, 0);
  endtask

  task automatic t_test_force();
    send(16'h0C00, 12);
    check("R10 eff normal", gnd_eff, 1);
    tforce = 1'b1;
    wait_clk(2);
    check("R10 eff forced", gnd_eff, 0);
    check("R10 flag kept", gnd_flag, 1);
    tforce = 1'b0;
    wait_clk(2);
    check("R10 eff restored", gnd_eff, 1);
  endtask

  task automatic t_coincident();
    open_and_shift(16'h0466, 12);
    sdata = 1'b1;
    sclk  = 1'b1;
    sen_n = 1'b1;
    wait_clk(12);
    sclk = 1'b0;
    wait_clk(4);
    expect_all("R11", 8'h66, 8'h5A, 0);
  endtask

  initial begin
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(3);
    t_reset();
    t_load_b();
    t_load_a();
    t_ground();
    t_release();
    t_hold_open();
    t_idle_scl();
    t_bad_len();
    t_test_force();
    t_coincident();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule